// File: doc/BRIEF.md
# Partial-Tag Cache Bank with Multi-Match Return

This block is one bank of a large banked cache that sits at the far end of a narrow 24-bit request link and a wide 128-bit response link. A read reaches the bank as a single flit that holds the set index and only the low eight bits of the tag. The bank reads the selected set and compares those eight bits against every valid way. Because the upper tag bits are never sent, more than one way can match. The bank therefore returns every matching way, in ascending way order. Each returned way is a header beat that carries the way number and the full stored tag, followed by the four data beats of the 64-byte line. The requester finishes the tag comparison itself and discards the false positives.

A write carries the complete address. Its first flit has the type bit set and holds the index. Three further flits each bring one byte of the 24-bit tag, lowest byte first. The four data beats then follow on a separate beat input. The write lands in the way whose full tag already matches. If no way matches, it goes to the lowest invalid way, and if the set is full it goes to way 0.

The controller is a state machine with states ST_IDLE, ST_WADDR, ST_WDATA, ST_LOOKUP, ST_HDR, ST_BEAT and ST_MISS. It has these transitions:
- ST_IDLE to ST_LOOKUP on a read flit, and ST_IDLE to ST_WADDR on a write flit.
- ST_WADDR to ST_WDATA on the third address flit.
- ST_WDATA to ST_IDLE on the fourth data beat.
- ST_LOOKUP to ST_HDR when any way matches, and ST_LOOKUP to ST_MISS when none does.
- ST_HDR to ST_BEAT always.
- ST_BEAT to ST_HDR after the fourth beat of a way when more matching ways remain, and ST_BEAT to ST_IDLE after the fourth beat of the last one.
- ST_MISS to ST_IDLE always.

Top module: `ptag_lookup_bank`

## Requirements
- R1: A flit accepted in idle with bit 23 clear is a read. Bits [5:0] give the set index and bits [13:6] give the partial tag. Bits [22:14] have no effect.
- R2: A way matches a read when it is valid and bits [7:0] of its stored 24-bit tag equal the partial tag. Tag bits [23:8] take no part in the compare, so ways that differ only in those bits all match.
- R3: Every matching way is returned in ascending way order. Each is a header beat followed by four data beats, with beat b carrying line bits [128b+127:128b].
- R4: A header beat has rsp_hdr high. Its bits [23:0] hold the full stored tag, bits [25:24] hold the way number, bit 127 is the miss flag, and all other bits are zero. Data beats have rsp_hdr low.
- R5: A read with no match returns exactly one header beat, with the miss flag set, way 0, tag 0 and rsp_last high.
- R6: The beats of one response are on consecutive cycles. rsp_last is high only on the final beat, and rsp_valid is low in the cycle after it.
- R7: The first response beat appears in the second cycle after the clock edge that accepts the read flit, which leaves one lookup cycle between them.
- R8: A flit accepted in idle with bit 23 set starts a write to the set index in bits [5:0]. The next three accepted flits carry tag bytes [7:0], [15:8] and [23:16] in their bits [7:0]. Four beats with wr_valid high then supply line beats 0 to 3 in order, and idle cycles may come between those beats.
- R9: The write goes to the valid way whose full tag equals the written tag. If there is none, it goes to the lowest invalid way, and if the set is full, to way 0. The way is then valid and holds the new tag and line.
- R10: in_ready is high only in ST_IDLE and ST_WADDR. Flits presented while in_ready is low, and wr_valid outside ST_WDATA, change neither the stored contents nor the response.
- R11: After reset every way is invalid, rsp_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request flit present |
| in_flit | input | 24 | Request flit |
| in_ready | output | 1 | Bank can take a flit this cycle |
| wr_valid | input | 1 | Write data beat present |
| wr_data | input | 128 | Write data beat |
| rsp_valid | output | 1 | Response beat present |
| rsp_hdr | output | 1 | Response beat is a header |
| rsp_last | output | 1 | Final beat of the response |
| rsp_data | output | 128 | Response beat |

## Verification
The assertions check the framing of the response on every cycle:
- A hit header is always followed by a data beat.
- A miss header is always the last beat.
- A response has no gaps, and rsp_last is followed by an idle cycle.
- in_ready is low while a response is being sent.
- Within one response, way numbers strictly increase.

Only the bench's scenarios can show the rest: which ways the eight-bit compare lets through, including false positives; that the full tag and line contents are correct; where a write lands (tag hit, free way, or full set); and that flits arriving while busy, or data beats arriving while idle, leave the stored contents unchanged.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WADDR,
        ST_WDATA,
        ST_LOOKUP,
        ST_HDR,
        ST_BEAT,
        ST_MISS
    } ptb_state_e;
endpackage

// File: rtl/ptb_way_pick.sv
module ptb_way_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] vec,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end
    assign any = |vec;
endmodule

// File: rtl/ptb_tag_array.sv
module ptb_tag_array #(
    parameter int IDX_W  = 6,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 24,
    parameter int PTAG_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            idx,
    input  logic [PTAG_W-1:0]           ptag,
    input  logic [TAG_W-1:0]            ftag,
    input  logic                        we,
    input  logic [$clog2(WAYS)-1:0]     we_way,
    input  logic [TAG_W-1:0]            we_tag,
    output logic [WAYS-1:0][TAG_W-1:0]  set_tags,
    output logic [WAYS-1:0]             set_valid,
    output logic [WAYS-1:0]             pmatch,
    output logic [WAYS-1:0]             fmatch
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tags [SETS][WAYS];
    logic [WAYS-1:0]  vld  [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld[s] <= '0;
        end else if (we) begin
            vld[idx][we_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) tags[idx][we_way] <= we_tag;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign set_tags[w]  = tags[idx][w];
        assign set_valid[w] = vld[idx][w];
        assign pmatch[w]    = vld[idx][w] && (tags[idx][w][PTAG_W-1:0] == ptag);
        assign fmatch[w]    = vld[idx][w] && (tags[idx][w] == ftag);
    end
endmodule

// File: rtl/ptb_data_array.sv
module ptb_data_array #(
    parameter int IDX_W  = 6,
    parameter int WAYS   = 4,
    parameter int BEATS  = 4,
    parameter int BEAT_W = 128
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [IDX_W-1:0]           idx,
    input  logic [$clog2(WAYS)-1:0]    wr_way,
    input  logic [$clog2(WAYS)-1:0]    rd_way,
    input  logic [$clog2(BEATS)-1:0]   beat,
    input  logic [BEAT_W-1:0]          wdata,
    output logic [BEAT_W-1:0]          rdata
);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int BEAT_B = $clog2(BEATS);
    localparam int ADR_W  = IDX_W + WAY_W + BEAT_B;
    localparam int DEPTH  = 1 << ADR_W;

    logic [BEAT_W-1:0] mem [DEPTH];
    logic [ADR_W-1:0]  wadr, radr;

    assign wadr = {idx, wr_way, beat};
    assign radr = {idx, rd_way, beat};

    always_ff @(posedge clk) begin
        if (we) mem[wadr] <= wdata;
    end

    assign rdata = mem[radr];
endmodule

// File: rtl/ptag_lookup_bank.sv
module ptag_lookup_bank #(
    parameter int FLIT_W = 24,
    parameter int IDX_W  = 6,
    parameter int PTAG_W = 8,
    parameter int TAG_W  = 24,
    parameter int WAYS   = 4,
    parameter int BEATS  = 4,
    parameter int BEAT_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FLIT_W-1:0] in_flit,
    output logic              in_ready,
    input  logic              wr_valid,
    input  logic [BEAT_W-1:0] wr_data,
    output logic              rsp_valid,
    output logic              rsp_hdr,
    output logic              rsp_last,
    output logic [BEAT_W-1:0] rsp_data
);
    import ptb_pkg::*;

    localparam int WAY_W      = $clog2(WAYS);
    localparam int BEAT_B     = $clog2(BEATS);
    localparam int TYPE_BIT   = FLIT_W - 1;
    localparam int ADDR_FLITS = TAG_W / PTAG_W;
    localparam int ACNT_W     = $clog2(ADDR_FLITS);
    localparam int MISS_BIT   = BEAT_W - 1;

    ptb_state_e st_q, st_d;

    logic [IDX_W-1:0]  idx_q;
    logic [PTAG_W-1:0] ptag_q;
    logic [TAG_W-1:0]  wtag_q;
    logic [ACNT_W-1:0] acnt_q;
    logic [BEAT_B-1:0] beat_q;
    logic [WAY_W-1:0]  wway_q;
    logic [WAYS-1:0]   mask_q;

    logic [TAG_W-1:0]            ftag_cmp;
    logic [WAYS-1:0][TAG_W-1:0]  set_tags;
    logic [WAYS-1:0]             set_valid, pmatch, fmatch;
    logic                        pm_any, fm_any, free_any, cur_any;
    logic [WAY_W-1:0]            pm_way, fm_way, free_way, cur_way;
    logic [WAYS-1:0]             rest_mask;
    logic [BEAT_W-1:0]           dat_rd;
    logic                        last_addr, last_beat, tag_we, dat_we;

    // Full tag as it will be once the current (final) address flit lands
    always_comb begin
        ftag_cmp = wtag_q;
        ftag_cmp[TAG_W-1 -: PTAG_W] = in_flit[PTAG_W-1:0];
    end

    assign last_addr = (acnt_q == ACNT_W'(ADDR_FLITS - 1));
    assign last_beat = (beat_q == BEAT_B'(BEATS - 1));
    assign tag_we    = (st_q == ST_WDATA) && wr_valid && last_beat;
    assign dat_we    = (st_q == ST_WDATA) && wr_valid;

    ptb_tag_array #(
        .IDX_W(IDX_W), .WAYS(WAYS), .TAG_W(TAG_W), .PTAG_W(PTAG_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(idx_q), .ptag(ptag_q), .ftag(ftag_cmp),
        .we(tag_we), .we_way(wway_q), .we_tag(wtag_q),
        .set_tags(set_tags), .set_valid(set_valid), .pmatch(pmatch), .fmatch(fmatch)
    );

    ptb_data_array #(
        .IDX_W(IDX_W), .WAYS(WAYS), .BEATS(BEATS), .BEAT_W(BEAT_W)
    ) u_data (
        .clk(clk), .we(dat_we), .idx(idx_q), .wr_way(wway_q), .rd_way(cur_way),
        .beat(beat_q), .wdata(wr_data), .rdata(dat_rd)
    );

    ptb_way_pick #(.N(WAYS), .W(WAY_W)) u_pick_pm   (.vec(pmatch),     .any(pm_any),   .idx(pm_way));
    ptb_way_pick #(.N(WAYS), .W(WAY_W)) u_pick_fm   (.vec(fmatch),     .any(fm_any),   .idx(fm_way));
    ptb_way_pick #(.N(WAYS), .W(WAY_W)) u_pick_free (.vec(~set_valid), .any(free_any), .idx(free_way));
    ptb_way_pick #(.N(WAYS), .W(WAY_W)) u_pick_cur  (.vec(mask_q),     .any(cur_any),  .idx(cur_way));

    always_comb begin
        rest_mask = mask_q;
        rest_mask[cur_way] = 1'b0;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (in_valid) st_d = in_flit[TYPE_BIT] ? ST_WADDR : ST_LOOKUP;
            ST_WADDR:  if (in_valid && last_addr) st_d = ST_WDATA;
            ST_WDATA:  if (wr_valid && last_beat) st_d = ST_IDLE;
            ST_LOOKUP: st_d = pm_any ? ST_HDR : ST_MISS;
            ST_HDR:    st_d = ST_BEAT;
            ST_BEAT:   if (last_beat) st_d = (rest_mask != '0) ? ST_HDR : ST_IDLE;
            ST_MISS:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        rsp_valid = 1'b0;
        rsp_hdr   = 1'b0;
        rsp_last  = 1'b0;
        rsp_data  = '0;
        unique case (st_q)
            ST_IDLE, ST_WADDR: in_ready = 1'b1;
            ST_HDR: begin
                rsp_valid = 1'b1;
                rsp_hdr   = 1'b1;
                rsp_data[TAG_W-1:0]       = set_tags[cur_way];
                rsp_data[TAG_W +: WAY_W]  = cur_way;
            end
            ST_BEAT: begin
                rsp_valid = 1'b1;
                rsp_data  = dat_rd;
                rsp_last  = last_beat && (rest_mask == '0);
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
                rsp_hdr   = 1'b1;
                rsp_last  = 1'b1;
                rsp_data[MISS_BIT] = 1'b1;
            end
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            ptag_q <= '0;
            wtag_q <= '0;
            acnt_q <= '0;
            beat_q <= '0;
            wway_q <= '0;
            mask_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (in_valid) begin
                    idx_q  <= in_flit[IDX_W-1:0];
                    ptag_q <= in_flit[IDX_W +: PTAG_W];
                    wtag_q <= '0;
                    acnt_q <= '0;
                    beat_q <= '0;
                end
                ST_WADDR: if (in_valid) begin
                    for (int i = 0; i < ADDR_FLITS; i++) begin
                        if (acnt_q == ACNT_W'(i)) wtag_q[i*PTAG_W +: PTAG_W] <= in_flit[PTAG_W-1:0];
                    end
                    acnt_q <= acnt_q + 1'b1;
                    if (last_addr) begin
                        wway_q <= fm_any ? fm_way : (free_any ? free_way : '0);
                        beat_q <= '0;
                    end
                end
                ST_WDATA: if (wr_valid) begin
                    beat_q <= last_beat ? '0 : beat_q + 1'b1;
                end
                ST_LOOKUP: begin
                    mask_q <= pmatch;
                    beat_q <= '0;
                end
                ST_BEAT: begin
                    beat_q <= last_beat ? '0 : beat_q + 1'b1;
                    if (last_beat) mask_q <= rest_mask;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ptb_checker.sv
module ptb_checker #(
    parameter int BEAT_W = 128,
    parameter int TAG_W  = 24,
    parameter int WAY_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              rsp_valid,
    input logic              rsp_hdr,
    input logic              rsp_last,
    input logic [BEAT_W-1:0] rsp_data
);
    logic             open_q;
    logic [WAY_W-1:0] prev_q;
    logic [WAY_W-1:0] way_now;
    logic             miss_now;

    assign way_now  = rsp_data[TAG_W +: WAY_W];
    assign miss_now = rsp_data[BEAT_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            prev_q <= '0;
        end else if (rsp_valid) begin
            if (rsp_last) open_q <= 1'b0;
            else if (rsp_hdr) begin
                open_q <= 1'b1;
                prev_q <= way_now;
            end
        end
    end

    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n) rsp_last |-> rsp_valid); // R6
    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_last) |=> rsp_valid); // R6
    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) rsp_last |=> !rsp_valid); // R6
    AST_BUSY_DURING_RSP: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !in_ready); // R10
    AST_HIT_HDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hdr && !miss_now) |=> (rsp_valid && !rsp_hdr)); // R3
    AST_MISS_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hdr && miss_now) |-> rsp_last); // R5
    AST_WAY_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hdr && open_q) |-> (way_now > prev_q)); // R3
endmodule

bind ptag_lookup_bank ptb_checker #(
    .BEAT_W(BEAT_W), .TAG_W(TAG_W), .WAY_W($clog2(WAYS))
) u_ptb_checker (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .rsp_valid(rsp_valid),
    .rsp_hdr(rsp_hdr), .rsp_last(rsp_last), .rsp_data(rsp_data)
);

// File: tb/tb_ptag_lookup_bank.sv
module tb_ptag_lookup_bank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [23:0]  in_flit = '0;
    logic         in_ready;
    logic         wr_valid = 1'b0;
    logic [127:0] wr_data = '0;
    logic         rsp_valid, rsp_hdr, rsp_last;
    logic [127:0] rsp_data;

    always #2 clk = ~clk;

    ptag_lookup_bank dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .in_ready(in_ready), .wr_valid(wr_valid), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_hdr(rsp_hdr), .rsp_last(rsp_last), .rsp_data(rsp_data)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string cur_req = "R11";

    bit           m_valid [64][4];
    logic [23:0]  m_tag   [64][4];
    logic [127:0] m_data  [64][4][4];

    bit           qv[$];
    bit           qh[$];
    bit           ql[$];
    logic [127:0] qd[$];

    function automatic logic [127:0] mk_beat(int seed, int b);
        return {32'(seed) * 32'h9E3779B1, ~32'(seed), 32'(seed) ^ 32'h5A5A5A5A, 32'(b) + 32'hC0DE0000};
    endfunction

    task automatic push(bit v, bit h, bit l, logic [127:0] d);
        qv.push_back(v); qh.push_back(h); ql.push_back(l); qd.push_back(d);
    endtask

    // Per-cycle comparison against the behavioural model
    always @(negedge clk) begin
        if (rst_n) begin
            bit ev, eh, el;
            logic [127:0] ed;
            ev = 0; eh = 0; el = 0; ed = '0;
            if (qv.size() > 0) begin
                ev = qv.pop_front(); eh = qh.pop_front();
                el = ql.pop_front(); ed = qd.pop_front();
            end
            checks++;
            if (rsp_valid !== ev || (ev && (rsp_hdr !== eh || rsp_last !== el || rsp_data !== ed))) begin
                errors++;
                $display("FAIL %s: act v=%0b h=%0b l=%0b d=%h exp v=%0b h=%0b l=%0b d=%h",
                         cur_req, rsp_valid, rsp_hdr, rsp_last, rsp_data, ev, eh, el, ed);
            end
        end
    end

    task automatic wait_ready();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
    endtask

    task automatic drain();
        while (qv.size() != 0) @(negedge clk);
    endtask

    // Expected stream for a read: one lookup bubble, then headers and beats (R7)
    task automatic expect_read(int idx, logic [7:0] ptag);
        int last_w;
        last_w = -1;
        for (int w = 0; w < 4; w++) if (m_valid[idx][w] && m_tag[idx][w][7:0] == ptag) last_w = w;
        push(0, 0, 0, '0);
        if (last_w < 0) begin
            push(1, 1, 1, {1'b1, 127'b0}); // R5
        end else begin
            for (int w = 0; w < 4; w++) begin
                if (m_valid[idx][w] && m_tag[idx][w][7:0] == ptag) begin
                    push(1, 1, 0, {102'b0, 2'(w), m_tag[idx][w]}); // R4
                    for (int b = 0; b < 4; b++) push(1, 0, (w == last_w) && (b == 3), m_data[idx][w][b]);
                end
            end
        end
    endtask

    task automatic do_read(int idx, logic [7:0] ptag, logic [8:0] junk, bit intrude);
        wait_ready();
        in_flit  = {1'b0, junk, ptag, 6'(idx)};
        in_valid = 1'b1;
        @(posedge clk);
        expect_read(idx, ptag);
        @(negedge clk);
        in_valid = 1'b0;
        if (intrude) begin
            // R10: flits and data beats while busy must be ignored
            in_flit  = {1'b1, 17'h0, 6'(idx)};
            in_valid = 1'b1;
            wr_valid = 1'b1;
            wr_data  = {4{32'hDEADBEEF}};
            @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            wr_valid = 1'b0;
        end
        drain();
    endtask

    task automatic do_write(int idx, logic [23:0] tag, int seed, bit gap);
        int way;
        way = -1;
        for (int w = 3; w >= 0; w--) if (m_valid[idx][w] && m_tag[idx][w] == tag) way = w;
        if (way < 0) for (int w = 3; w >= 0; w--) if (!m_valid[idx][w]) way = w;
        if (way < 0) way = 0;
        m_valid[idx][way] = 1;
        m_tag[idx][way]   = tag;
        for (int b = 0; b < 4; b++) m_data[idx][way][b] = mk_beat(seed, b);
        wait_ready();
        in_flit  = {1'b1, 17'h0, 6'(idx)};
        in_valid = 1'b1;
        @(posedge clk);
        for (int f = 0; f < 3; f++) begin
            @(negedge clk);
            in_flit = {16'h0, tag[f*8 +: 8]};
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        for (int b = 0; b < 4; b++) begin
            if (gap && b == 2) @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = mk_beat(seed, b);
            @(posedge clk);
            @(negedge clk);
            wr_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: act running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (in_ready !== 1'b1 || rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11: act ready=%0b valid=%0b exp ready=1 valid=0", in_ready, rsp_valid);
        end

        cur_req = "R11 R5"; do_read(5, 8'h56, 9'h0, 0);
        cur_req = "R5";     do_read(63, 8'h00, 9'h0, 0);

        cur_req = "R8 R9";  do_write(5, 24'h123456, 1, 0);
        cur_req = "R3 R7";  do_read(5, 8'h56, 9'h0, 0);
        cur_req = "R8";     do_write(5, 24'hABCD56, 2, 1);
        cur_req = "R9";     do_write(5, 24'h000077, 3, 0);
        cur_req = "R9";     do_write(5, 24'hFFFF56, 4, 0);

        cur_req = "R2 R3 R6"; do_read(5, 8'h56, 9'h0, 0);
        cur_req = "R4";       do_read(5, 8'h77, 9'h0, 0);
        cur_req = "R1";       do_read(5, 8'h77, 9'h1FF, 0);
        cur_req = "R5";       do_read(5, 8'h99, 9'h0AA, 0);

        cur_req = "R9";     do_write(5, 24'hABCD56, 5, 0);
        cur_req = "R9 R3";  do_read(5, 8'h56, 9'h0, 0);
        cur_req = "R9";     do_write(5, 24'h010101, 6, 0);
        cur_req = "R9";     do_read(5, 8'h01, 9'h0, 0);
        cur_req = "R2";     do_read(5, 8'h56, 9'h0, 0);

        cur_req = "R10";    do_read(5, 8'h77, 9'h0, 1);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = '1;
        @(negedge clk);
        wr_valid = 1'b0;
        cur_req = "R10";    do_read(5, 8'h56, 9'h0, 0);
        cur_req = "R10";    do_read(5, 8'h77, 9'h0, 0);

        cur_req = "R8 R1";  do_write(63, 24'h0000AA, 7, 0);
        cur_req = "R1";     do_read(63, 8'hAA, 9'h0, 0);
        cur_req = "R5";     do_read(0, 8'hAA, 9'h0, 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule